// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers interrupt sources for a processor and presents them through two local request levels, each fed by eight source lines. A third bank of eight mappable sources shares one status register but carries a separate mask for each level. Any mappable source that is enabled in a level's mappable mask reaches that level through a dedicated cascade bit in the level's own status. Software programs the masks and reads status and the winning source of each level through a small register bus. A registered selector picks one processor interrupt line at a time from the processor timer, the two local levels, a bus-error line and two counter-timer lines.

Every external source line passes through a two-flop synchroniser. Status bits are level-sensitive and follow the synchronised lines. The winning source of each level comes from a priority encoder in which the highest-numbered pending bit wins.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Every source line reaches its status bit through exactly two clock edges of synchronisation. After one edge, the status read still shows the old value. After two edges it shows the new value.
- R2: A level's pending set is its status AND its effective mask. The level request output is high one edge after that set becomes non-empty, which is three edges after the source change.
- R3: Bit 7 of each level status is the cascade bit. It reads 1 whenever any mappable status bit is 1. Input line 7 of either level's own sources is ignored.
- R4: The vector register of a level reads bit 7 = valid, bit 3 = group (1 means mappable), and bits 2:0 = source index. The highest-numbered pending bit wins. With nothing pending the register reads 0x00.
- R5: When a level's cascade bit is pending, its vector is taken from mappable status AND that level's mappable mask. Own bits of the level are not used in that case, and the two levels use independent mappable masks.
- R6: Writing a non-zero value to a level's mappable mask sets bit 7 of that level's mask. Writing zero clears it. Bit 7 of a write to a level mask is ignored.
- R7: After reset, every mask register reads 0x00 and every request output is low.
- R8: The processor line selector reports one code per cycle, by fixed priority from highest to lowest: 1 = processor timer, 2 = level 0, 3 = level 1, 4 = bus error, 5 = either counter timer. It reports 0 when nothing is pending. The request output is high exactly when the code is non-zero.
- R9: If level 0's cascade bit is pending but no enabled mappable source is found, the vector of level 0 reads 0x80 (own group, bit 0). Level 1 in the same state reads 0x00.
- R10: Writes to any status or vector offset leave the read values unchanged.
- R11: The register offsets are: 0 level-0 status, 1 level-0 mask, 2 level-1 status, 3 level-1 mask, 4 mappable status, 5 level-0 mappable mask, 6 level-1 mappable mask, 7 level-0 vector, 8 level-1 vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_src_i | input | 8 | Level 0 source lines (line 7 unused) |
| l1_src_i | input | 8 | Level 1 source lines (line 7 unused) |
| map_src_i | input | 8 | Mappable source lines |
| cpu_tmr_i | input | 1 | Processor timer line |
| bus_err_i | input | 1 | Bus-error line |
| tmr0_i | input | 1 | Counter timer 0 line |
| tmr1_i | input | 1 | Counter timer 1 line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current offset |
| lvl0_irq_o | output | 1 | Level 0 request |
| lvl1_irq_o | output | 1 | Level 1 request |
| cpu_req_o | output | 1 | Any processor line selected |
| cpu_sel_o | output | 3 | Selected processor line code |

## Verification
The bench checks the cascade coupling. A design that does not set or clear the level mask's cascade bit with the mappable mask would miss cascaded requests, or would keep them after all mappable sources are disabled. It checks that a pending cascade bit overrides lower own bits and uses only its own level's mappable mask; a shared-mask error shows up as identical vectors on both levels. It checks the fallback, where a wrong design reports 0x00 on level 0 or a spurious 0x80 on level 1. It also checks the exact synchroniser latency and the processor-line priority order, where a swapped slot reports the wrong code.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
    localparam logic [3:0] A_L0_STAT   = 4'd0;
    localparam logic [3:0] A_L0_MASK   = 4'd1;
    localparam logic [3:0] A_L1_STAT   = 4'd2;
    localparam logic [3:0] A_L1_MASK   = 4'd3;
    localparam logic [3:0] A_MAP_STAT  = 4'd4;
    localparam logic [3:0] A_MAP_MASK0 = 4'd5;
    localparam logic [3:0] A_MAP_MASK1 = 4'd6;
    localparam logic [3:0] A_VEC0      = 4'd7;
    localparam logic [3:0] A_VEC1      = 4'd8;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_CPUTMR = 3'd1,
        SEL_LVL0   = 3'd2,
        SEL_LVL1   = 3'd3,
        SEL_BUSERR = 3'd4,
        SEL_TMR    = 3'd5
    } cpu_sel_e;
endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cirq_prio_enc.sv
module cirq_prio_enc #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int b = 0; b < N; b++) begin
            if (req_i[b]) begin
                idx_o = IW'(b);
            end
        end
    end
endmodule

// File: rtl/cirq_level_sel.sv
module cirq_level_sel #(
    parameter int N        = 8,
    parameter int CASC     = N - 1,
    parameter bit FALLBACK = 1'b0
) (
    input  logic [N-1:0] own_pend_i,
    input  logic [N-1:0] map_pend_i,
    output logic         req_o,
    output logic [N-1:0] vec_o
);
    localparam int IW      = $clog2(N);
    localparam int GRP_BIT = IW;
    localparam int VAL_BIT = N - 1;

    logic          own_any, map_any;
    logic [IW-1:0] own_idx, map_idx;
    logic [N-1:0]  miss_vec;

    cirq_prio_enc #(.N(N), .IW(IW)) u_own_enc (
        .req_i (own_pend_i),
        .any_o (own_any),
        .idx_o (own_idx)
    );

    cirq_prio_enc #(.N(N), .IW(IW)) u_map_enc (
        .req_i (map_pend_i),
        .any_o (map_any),
        .idx_o (map_idx)
    );

    generate
        if (FALLBACK) begin : g_fallback
            always_comb begin
                miss_vec          = '0;
                miss_vec[VAL_BIT] = 1'b1;
            end
        end else begin : g_silent
            assign miss_vec = '0;
        end
    endgenerate

    always_comb begin
        req_o = own_any;
        vec_o = '0;
        if (own_pend_i[CASC]) begin
            if (map_any) begin
                vec_o[VAL_BIT]  = 1'b1;
                vec_o[GRP_BIT]  = 1'b1;
                vec_o[IW-1:0]   = map_idx;
            end else begin
                vec_o = miss_vec;
            end
        end else if (own_any) begin
            vec_o[VAL_BIT] = 1'b1;
            vec_o[IW-1:0]  = own_idx;
        end
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter int N           = 8,
    parameter int CASC        = N - 1,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      l0_src_i,
    input  logic [N-1:0]      l1_src_i,
    input  logic [N-1:0]      map_src_i,
    input  logic              cpu_tmr_i,
    input  logic              bus_err_i,
    input  logic              tmr0_i,
    input  logic              tmr1_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [N-1:0]      reg_wdata_i,
    output logic [N-1:0]      reg_rdata_o,
    output logic              lvl0_irq_o,
    output logic              lvl1_irq_o,
    output logic              cpu_req_o,
    output logic [2:0]        cpu_sel_o
);
    import cirq_pkg::*;

    localparam int NLVL  = 2;
    localparam int SYN_W = 3 * N + 4;

    typedef struct packed {
        logic [NLVL-1:0][N-1:0] mask;
        logic [NLVL-1:0][N-1:0] mapmask;
        logic [NLVL-1:0]        casc_en;
        logic [NLVL-1:0]        lvl_irq;
        logic                   cpu_req;
        cpu_sel_e               cpu_sel;
    } state_t;

    state_t st_d, st_q;

    // synchronised sources
    logic [SYN_W-1:0] syn_in, syn_out;
    logic [N-1:0]     l0_s, l1_s, map_s;
    logic             cpu_tmr_s, bus_err_s, tmr0_s, tmr1_s;

    assign syn_in = {tmr1_i, tmr0_i, bus_err_i, cpu_tmr_i, map_src_i, l1_src_i, l0_src_i};

    cirq_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (syn_in),
        .q_o   (syn_out)
    );

    assign {tmr1_s, tmr0_s, bus_err_s, cpu_tmr_s, map_s, l1_s, l0_s} = syn_out;

    // per-level status, pending and vector
    logic [NLVL-1:0][N-1:0] own_src;
    logic [NLVL-1:0][N-1:0] stat_w;
    logic [NLVL-1:0][N-1:0] vec_w;
    logic [NLVL-1:0][N-1:0] pend_w;
    logic [NLVL-1:0]        req_w;

    assign own_src = {l1_s, l0_s};

    generate
        for (genvar l = 0; l < NLVL; l++) begin : g_lvl
            logic [N-1:0] stat_g, eff_g, mpend_g;

            always_comb begin
                stat_g       = own_src[l];
                stat_g[CASC] = |map_s;
                eff_g        = st_q.mask[l];
                eff_g[CASC]  = st_q.casc_en[l];
                mpend_g      = map_s & st_q.mapmask[l];
            end

            assign stat_w[l] = stat_g;
            assign pend_w[l] = stat_g & eff_g;

            cirq_level_sel #(.N(N), .CASC(CASC), .FALLBACK(l == 0)) u_sel (
                .own_pend_i (stat_g & eff_g),
                .map_pend_i (mpend_g),
                .req_o      (req_w[l]),
                .vec_o      (vec_w[l])
            );
        end
    endgenerate

    // next-state
    always_comb begin
        st_d = st_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_L0_MASK:   st_d.mask[0] = reg_wdata_i;
                A_L1_MASK:   st_d.mask[1] = reg_wdata_i;
                A_MAP_MASK0: begin
                    st_d.mapmask[0] = reg_wdata_i;
                    st_d.casc_en[0] = |reg_wdata_i;
                end
                A_MAP_MASK1: begin
                    st_d.mapmask[1] = reg_wdata_i;
                    st_d.casc_en[1] = |reg_wdata_i;
                end
                default: ;
            endcase
        end
        for (int l = 0; l < NLVL; l++) begin
            st_d.mask[l][CASC] = 1'b0;
        end

        st_d.lvl_irq = req_w;

        if (cpu_tmr_s)             st_d.cpu_sel = SEL_CPUTMR;
        else if (req_w[0])         st_d.cpu_sel = SEL_LVL0;
        else if (req_w[1])         st_d.cpu_sel = SEL_LVL1;
        else if (bus_err_s)        st_d.cpu_sel = SEL_BUSERR;
        else if (tmr0_s | tmr1_s)  st_d.cpu_sel = SEL_TMR;
        else                       st_d.cpu_sel = SEL_NONE;

        st_d.cpu_req = cpu_tmr_s | (|req_w) | bus_err_s | tmr0_s | tmr1_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_L0_STAT:   reg_rdata_o = stat_w[0];
            A_L0_MASK:   begin
                reg_rdata_o       = st_q.mask[0];
                reg_rdata_o[CASC] = st_q.casc_en[0];
            end
            A_L1_STAT:   reg_rdata_o = stat_w[1];
            A_L1_MASK:   begin
                reg_rdata_o       = st_q.mask[1];
                reg_rdata_o[CASC] = st_q.casc_en[1];
            end
            A_MAP_STAT:  reg_rdata_o = map_s;
            A_MAP_MASK0: reg_rdata_o = st_q.mapmask[0];
            A_MAP_MASK1: reg_rdata_o = st_q.mapmask[1];
            A_VEC0:      reg_rdata_o = vec_w[0];
            A_VEC1:      reg_rdata_o = vec_w[1];
            default:     reg_rdata_o = '0;
        endcase
    end

    assign lvl0_irq_o = st_q.lvl_irq[0];
    assign lvl1_irq_o = st_q.lvl_irq[1];
    assign cpu_req_o  = st_q.cpu_req;
    assign cpu_sel_o  = st_q.cpu_sel;

    // signals for the bound checker
    logic [NLVL-1:0] chk_casc_en;
    logic [N-1:0]    chk_mapmask0, chk_mapmask1, chk_mask0, chk_mask1;
    logic            chk_pend0, chk_pend1;

    assign chk_casc_en  = st_q.casc_en;
    assign chk_mapmask0 = st_q.mapmask[0];
    assign chk_mapmask1 = st_q.mapmask[1];
    assign chk_mask0    = st_q.mask[0];
    assign chk_mask1    = st_q.mask[1];
    assign chk_pend0    = |pend_w[0];
    assign chk_pend1    = |pend_w[1];
endmodule

// File: rtl/cirq_checks.sv
module cirq_checks #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   casc_en,
    input logic [N-1:0] mapmask0,
    input logic [N-1:0] mapmask1,
    input logic [N-1:0] mask0,
    input logic [N-1:0] mask1,
    input logic         pend0,
    input logic         pend1,
    input logic         cpu_tmr_s,
    input logic         lvl0_irq,
    input logic         lvl1_irq,
    input logic         cpu_req,
    input logic [2:0]   cpu_sel
);
    // R6: cascade enable tracks whether the mappable mask is non-zero
    p_casc_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_en[0] == (|mapmask0)) && (casc_en[1] == (|mapmask1)));

    // R2: level request follows the pending set one edge later
    p_lvl0_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend0 |=> lvl0_irq);
    p_lvl1_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pend1 |=> !lvl1_irq);

    // R8: processor timer always wins the selector
    p_cputmr_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tmr_s |=> (cpu_sel == 3'd1));

    // R8: request high exactly when a code is selected
    p_req_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req == (cpu_sel != 3'd0));

    // R7: masks are clear on the first edge out of reset
    p_reset_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask0 == '0 && mask1 == '0 && mapmask0 == '0 && mapmask1 == '0));
endmodule

bind cascade_irq_ctrl cirq_checks #(.N(N)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .casc_en   (chk_casc_en),
    .mapmask0  (chk_mapmask0),
    .mapmask1  (chk_mapmask1),
    .mask0     (chk_mask0),
    .mask1     (chk_mask1),
    .pend0     (chk_pend0),
    .pend1     (chk_pend1),
    .cpu_tmr_s (cpu_tmr_s),
    .lvl0_irq  (lvl0_irq_o),
    .lvl1_irq  (lvl1_irq_o),
    .cpu_req   (cpu_req_o),
    .cpu_sel   (cpu_sel_o)
);

// File: tb/tb_cascade_irq_ctrl.sv
module tb_cascade_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] l0_src = '0, l1_src = '0, map_src = '0;
    logic       cpu_tmr = 1'b0, bus_err = 1'b0, tmr0 = 1'b0, tmr1 = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       lvl0_irq, lvl1_irq, cpu_req;
    logic [2:0] cpu_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .l0_src_i    (l0_src),
        .l1_src_i    (l1_src),
        .map_src_i   (map_src),
        .cpu_tmr_i   (cpu_tmr),
        .bus_err_i   (bus_err),
        .tmr0_i      (tmr0),
        .tmr1_i      (tmr1),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .lvl0_irq_o  (lvl0_irq),
        .lvl1_irq_o  (lvl1_irq),
        .cpu_req_o   (cpu_req),
        .cpu_sel_o   (cpu_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        l0_src = '0; l1_src = '0; map_src = '0;
        cpu_tmr = 0; bus_err = 0; tmr0 = 0; tmr1 = 0; reg_wr = 0;
        settle(2);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        for (int a = 1; a <= 6; a++) begin
            if (a == 2 || a == 4) continue;
            rd(4'(a), d);
            check("R7 mask after reset", d, 0);
        end
        check("R7 lvl0 irq", lvl0_irq, 0);
        check("R7 cpu req", cpu_req, 0);
        check("R8 idle code", cpu_sel, 0);
    endtask

    task automatic t_sync();
        logic [7:0] d;
        do_reset();
        @(negedge clk); l0_src = 8'h04;
        @(posedge clk); #1;
        reg_addr = 4'd0; #1 d = reg_rdata;
        check("R1 one edge", d, 8'h00);
        @(posedge clk); #1;
        reg_addr = 4'd0; #1 d = reg_rdata;
        check("R1 two edges", d, 8'h04);
    endtask

    task automatic t_level_mask();
        logic [7:0] d;
        do_reset();
        l0_src = 8'h04;
        settle(3);
        check("R2 masked source no request", lvl0_irq, 0);
        wr(4'd1, 8'h04);
        settle(1);
        check("R2 request after unmask", lvl0_irq, 1);
        check("R8 level0 code", cpu_sel, 2);
        rd(4'd7, d);
        check("R4 single bit vector", d, 8'h82);
        l0_src = 8'h00;
        settle(3);
        check("R2 request drops", lvl0_irq, 0);
        rd(4'd7, d);
        check("R4 empty vector", d, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        do_reset();
        wr(4'd1, 8'h7F);
        wr(4'd3, 8'h7F);
        l0_src = 8'h26; l1_src = 8'h03;
        settle(3);
        rd(4'd7, d);
        check("R4 highest wins lvl0", d, 8'h85);
        rd(4'd8, d);
        check("R4 highest wins lvl1", d, 8'h81);
        check("R11 lvl1 irq", lvl1_irq, 1);
    endtask

    task automatic t_bit7_ignored();
        logic [7:0] d;
        do_reset();
        wr(4'd1, 8'hFF);
        rd(4'd1, d);
        check("R6 mask bit7 write ignored", d, 8'h7F);
        l0_src = 8'h80;
        settle(3);
        rd(4'd0, d);
        check("R3 input line 7 ignored", d, 8'h00);
        check("R3 no request from line 7", lvl0_irq, 0);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        do_reset();
        wr(4'd1, 8'h05);
        l0_src = 8'h05; map_src = 8'h48;
        settle(3);
        rd(4'd0, d);
        check("R3 cascade status bit", d, 8'h85);
        rd(4'd4, d);
        check("R11 mappable status", d, 8'h48);
        rd(4'd7, d);
        check("R4 own bits before cascade", d, 8'h82);
        wr(4'd5, 8'h08);
        rd(4'd1, d);
        check("R6 cascade enable set", d, 8'h85);
        rd(4'd7, d);
        check("R5 cascade overrides own", d, 8'h8B);
        wr(4'd6, 8'h40);
        settle(1);
        rd(4'd8, d);
        check("R5 independent mask lvl1", d, 8'h8E);
        check("R5 lvl1 irq via cascade", lvl1_irq, 1);
        wr(4'd5, 8'h00);
        rd(4'd1, d);
        check("R6 cascade enable cleared", d, 8'h05);
        rd(4'd7, d);
        check("R5 back to own bits", d, 8'h82);
    endtask

    task automatic t_fallback();
        logic [7:0] d;
        do_reset();
        map_src = 8'h01;
        wr(4'd5, 8'h02);
        wr(4'd6, 8'h02);
        settle(3);
        rd(4'd7, d);
        check("R9 lvl0 fallback", d, 8'h80);
        rd(4'd8, d);
        check("R9 lvl1 none", d, 8'h00);
        check("R9 lvl0 still requests", lvl0_irq, 1);
    endtask

    task automatic t_status_write();
        logic [7:0] d;
        do_reset();
        l1_src = 8'h11;
        settle(2);
        wr(4'd2, 8'hFF);
        wr(4'd4, 8'hFF);
        wr(4'd8, 8'hFF);
        rd(4'd2, d);
        check("R10 status write ignored", d, 8'h11);
        rd(4'd4, d);
        check("R10 map status write ignored", d, 8'h00);
        rd(4'd8, d);
        check("R10 vector write ignored", d, 8'h00);
    endtask

    task automatic t_cpu_prio();
        do_reset();
        wr(4'd1, 8'h01);
        wr(4'd3, 8'h01);
        l0_src = 8'h01; l1_src = 8'h01;
        cpu_tmr = 1; bus_err = 1; tmr1 = 1;
        settle(3);
        check("R8 timer highest", cpu_sel, 1);
        cpu_tmr = 0; settle(3);
        check("R8 level0 next", cpu_sel, 2);
        l0_src = 0; settle(3);
        check("R8 level1 next", cpu_sel, 3);
        l1_src = 0; settle(3);
        check("R8 bus error next", cpu_sel, 4);
        bus_err = 0; settle(3);
        check("R8 counter timer last", cpu_sel, 5);
        check("R8 req with timer", cpu_req, 1);
        tmr1 = 0; tmr0 = 1; settle(3);
        check("R8 counter timer 0", cpu_sel, 5);
        tmr0 = 0; settle(3);
        check("R8 none", cpu_sel, 0);
        check("R8 req low", cpu_req, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_sync();
        t_level_mask();
        t_priority();
        t_bit7_ignored();
        t_cascade();
        t_fallback();
        t_status_write();
        t_cpu_prio();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule